// File: doc/BRIEF.md
# Dual-Source Interrupt Status Controller

This block gathers event pulses from two producers, a hash core and a DMA engine, into two independent sticky status registers. Each source has its own enable register; the DMA source also carries a single global unmask bit that must be set before any of its enabled bits can reach the interrupt line. Software clears pending events by writing ones to the status register, and a write of all ones clears everything pending on that source.

A single interrupt output is asserted while any enabled, and for the DMA source unmasked, status bit is set. Two summary outputs split that condition into a done class (hash completion, DMA source completion) and an error class (every other defined event bit), so a handler can tell a normal completion from a fault without reading registers first. Registers are reached through a simple single-cycle write strobe with a combinational read data path. The logic that produces the events is outside this block.

The block has no sequencing state: every register updates on the clock edge that follows its input, and all three outputs are combinational functions of the registered status, enable and unmask values.

Top module: `irq_hub_top`

## Requirements
- R1: After reset every status, enable and unmask bit is zero, irq, done_sum and err_sum are low, and every register reads as zero.
- R2: A high event input bit sets the matching status bit on the next clock edge. The hash status register (address 0x050) defines bits 0 to 3, and the DMA status register (address 0x480) defines bits 0 and 2 to 8. DMA bit 1 never sets, and undefined bits read as zero.
- R3: Writing a status register clears exactly the bits written as 1 and leaves the bits written as 0 unchanged. Writing 0xFFFFFFFF clears every pending bit of that source.
- R4: When an event and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R5: A status bit stays set until it is cleared, whatever its enable. The enable registers (hash at 0x054, DMA at 0x484) store and read back only the defined bits, and writing 0 to an enable register stops that source from driving any output.
- R6: irq is high exactly when (hash status AND hash enable) is nonzero, or when (DMA status AND DMA enable) is nonzero while bit 0 of the unmask register (address 0x488) is 1.
- R7: done_sum is high exactly when hash bit 2 is set and enabled, or when DMA bit 0 is set, enabled and unmasked.
- R8: err_sum is high exactly when any of hash bits 0, 1 or 3 is set and enabled, or when any of DMA bits 2 to 8 is set, enabled and unmasked.
- R9: A write to any other address changes no register, and a read of any other address returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe, one write per cycle while high |
| reg_addr | input | 12 | Byte address for the write and the read |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the register at reg_addr, combinational |
| hash_evt | input | 4 | Hash core event pulses, one bit per event |
| dma_evt | input | 9 | DMA engine event pulses, one bit per event |
| irq | output | 1 | Combined interrupt request |
| done_sum | output | 1 | Enabled done event pending |
| err_sum | output | 1 | Enabled error event pending |

## Verification
The hash side is swept over all 16 status patterns against all 16 enable patterns, which separates the done bit from the three error bits and shows that irq covers both classes. The DMA side is swept one event bit at a time, with a matching single-bit enable and with a full enable, under both unmask values. This exposes the undefined bit 1, the gating by the unmask bit and the split between the done and error classes. Directed sequences cover partial and full clears, a write of zero, an event that coincides with a clear, a clear of one bit while another sets, and writes to an unmapped address.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;
    localparam int HASH_W = 4;
    localparam int DMA_W  = 9;

    localparam logic [ADDR_W-1:0] OFS_HASH_STAT = 12'h050;
    localparam logic [ADDR_W-1:0] OFS_HASH_EN   = 12'h054;
    localparam logic [ADDR_W-1:0] OFS_DMA_STAT  = 12'h480;
    localparam logic [ADDR_W-1:0] OFS_DMA_EN    = 12'h484;
    localparam logic [ADDR_W-1:0] OFS_DMA_GATE  = 12'h488;

    localparam logic [HASH_W-1:0] HASH_DONE_M = 4'b0100;
    localparam logic [HASH_W-1:0] HASH_ERR_M  = 4'b1011;
    localparam logic [DMA_W-1:0]  DMA_DONE_M  = 9'h001;
    localparam logic [DMA_W-1:0]  DMA_ERR_M   = 9'h1FC;

    typedef struct packed {
        logic hash_stat;
        logic hash_en;
        logic dma_stat;
        logic dma_en;
        logic dma_gate;
    } reg_sel_t;
endpackage

// File: rtl/irq_addr_dec.sv
module irq_addr_dec
    import irq_hub_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    output reg_sel_t          sel,
    output reg_sel_t          wstb
);
    always_comb begin
        sel = '0;
        unique case (addr)
            OFS_HASH_STAT: sel.hash_stat = 1'b1;
            OFS_HASH_EN:   sel.hash_en   = 1'b1;
            OFS_DMA_STAT:  sel.dma_stat  = 1'b1;
            OFS_DMA_EN:    sel.dma_en    = 1'b1;
            OFS_DMA_GATE:  sel.dma_gate  = 1'b1;
            default:       sel = '0;
        endcase
        wstb = wr ? sel : '0;
    end

    // R9: at most one register is ever addressed
    a_r9_onehot_sel: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wstb));
endmodule

// File: rtl/irq_src_bank.sv
module irq_src_bank #(
    parameter int             W        = 4,
    parameter int             DATA_W   = 32,
    parameter logic [W-1:0]   DONE_M   = '0,
    parameter logic [W-1:0]   ERR_M    = '0,
    parameter bit             HAS_GATE = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [W-1:0]      evt,
    input  logic              clr_wr,
    input  logic              en_wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              gate,
    output logic [W-1:0]      stat_q,
    output logic [W-1:0]      en_q,
    output logic              done_p,
    output logic              err_p
);
    localparam logic [W-1:0] VALID_M = DONE_M | ERR_M;

    logic [W-1:0] stat_nxt;
    logic [W-1:0] wbits;
    logic [W-1:0] live;
    logic         open_q;

    assign wbits = wdata[W-1:0];

    always_comb begin
        stat_nxt = stat_q;
        if (clr_wr)
            stat_nxt = stat_nxt & ~wbits;
        stat_nxt = (stat_nxt | evt) & VALID_M;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
            en_q   <= '0;
        end else begin
            stat_q <= stat_nxt;
            if (en_wr)
                en_q <= wbits & VALID_M;
        end
    end

    generate
        if (HAS_GATE) begin : g_gated
            assign open_q = gate;
        end else begin : g_open
            assign open_q = 1'b1;
        end
    endgenerate

    assign live   = open_q ? (stat_q & en_q) : '0;
    assign done_p = |(live & DONE_M);
    assign err_p  = |(live & ERR_M);

    // R2 and R4: a defined event bit is set after the edge, even under a clear
    a_r2_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (|(evt & VALID_M)) |=> ((stat_q & $past(evt & VALID_M)) == $past(evt & VALID_M)));

    // R3: bits written as 1 without a coinciding event are gone
    a_r3_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr |=> ((stat_q & $past(wbits & ~evt)) == '0));

    // R5: without a clearing write no set bit is lost
    a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_wr |=> ((stat_q & $past(stat_q)) == $past(stat_q)));
endmodule

// File: rtl/irq_hub_top.sv
module irq_hub_top
    import irq_hub_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [HASH_W-1:0] hash_evt,
    input  logic [DMA_W-1:0]  dma_evt,
    output logic              irq,
    output logic              done_sum,
    output logic              err_sum
);
    reg_sel_t          sel;
    reg_sel_t          wstb;
    logic              gate_q;
    logic [HASH_W-1:0] h_stat, h_en;
    logic [DMA_W-1:0]  d_stat, d_en;
    logic              h_done, h_err, d_done, d_err;

    irq_addr_dec u_dec (
        .clk  (clk),
        .rst_n(rst_n),
        .addr (reg_addr),
        .wr   (reg_wr),
        .sel  (sel),
        .wstb (wstb)
    );

    irq_src_bank #(
        .W(HASH_W), .DATA_W(DATA_W), .DONE_M(HASH_DONE_M), .ERR_M(HASH_ERR_M), .HAS_GATE(1'b0)
    ) u_hash (
        .clk(clk), .rst_n(rst_n), .evt(hash_evt),
        .clr_wr(wstb.hash_stat), .en_wr(wstb.hash_en), .wdata(reg_wdata),
        .gate(1'b1), .stat_q(h_stat), .en_q(h_en), .done_p(h_done), .err_p(h_err)
    );

    irq_src_bank #(
        .W(DMA_W), .DATA_W(DATA_W), .DONE_M(DMA_DONE_M), .ERR_M(DMA_ERR_M), .HAS_GATE(1'b1)
    ) u_dma (
        .clk(clk), .rst_n(rst_n), .evt(dma_evt),
        .clr_wr(wstb.dma_stat), .en_wr(wstb.dma_en), .wdata(reg_wdata),
        .gate(gate_q), .stat_q(d_stat), .en_q(d_en), .done_p(d_done), .err_p(d_err)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)
            gate_q <= 1'b0;
        else if (wstb.dma_gate)
            gate_q <= reg_wdata[0];
    end

    always_comb begin
        reg_rdata = '0;
        if (sel.hash_stat) reg_rdata[HASH_W-1:0] = h_stat;
        if (sel.hash_en)   reg_rdata[HASH_W-1:0] = h_en;
        if (sel.dma_stat)  reg_rdata[DMA_W-1:0]  = d_stat;
        if (sel.dma_en)    reg_rdata[DMA_W-1:0]  = d_en;
        if (sel.dma_gate)  reg_rdata[0]          = gate_q;
    end

    assign done_sum = h_done | d_done;
    assign err_sum  = h_err | d_err;
    assign irq      = done_sum | err_sum;

    // R6: with the DMA source masked only the hash side reaches irq
    a_r6_gate_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_q |-> (irq == (|(h_stat & h_en))));

    // R8: an error summary always comes with an interrupt
    a_r8_err_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
        err_sum |-> irq);

    // R1: the cycle after reset nothing is pending
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        !rst_n |=> (!irq && !done_sum && !err_sum));
endmodule

// File: tb/irq_hub_top_test.sv
`timescale 1ns/1ps
module irq_hub_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [3:0]  hash_evt = '0;
    logic [8:0]  dma_evt = '0;
    logic        irq, done_sum, err_sum;

    int errors = 0;
    int checks = 0;

    localparam logic [11:0] A_HS = 12'h050, A_HE = 12'h054;
    localparam logic [11:0] A_DS = 12'h480, A_DE = 12'h484, A_DG = 12'h488;
    localparam logic [8:0]  D_VALID = 9'h1FD;

    always #10 clk = ~clk;

    irq_hub_top uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hash_evt(hash_evt),
        .dma_evt(dma_evt), .irq(irq), .done_sum(done_sum), .err_sum(err_sum)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] v);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic pulse(input logic [3:0] h, input logic [8:0] d);
        @(negedge clk);
        hash_evt = h; dma_evt = d;
        @(negedge clk);
        hash_evt = '0; dma_evt = '0;
    endtask

    task automatic clear_all();
        bus_wr(A_HS, 32'hFFFF_FFFF);
        bus_wr(A_DS, 32'hFFFF_FFFF);
    endtask

    logic [31:0] v;

    initial begin
        #(20ns * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 irq", {31'd0, irq}, 0);
        chk("R1 done", {31'd0, done_sum}, 0);
        chk("R1 err", {31'd0, err_sum}, 0);
        foreach (v[i]) if (i < 5) begin
            logic [11:0] al [5] = '{A_HS, A_HE, A_DS, A_DE, A_DG};
            rd(al[i], v); chk("R1 read zero", v, 0);
        end

        // Hash sweep: R2 R6 R7 R8 R5
        for (int s = 0; s < 16; s++) begin
            for (int e = 0; e < 16; e++) begin
                clear_all();
                bus_wr(A_HE, 32'(e));
                pulse(4'(s), 9'd0);
                rd(A_HS, v); chk("R2 hash status", v, 32'(s));
                rd(A_HE, v); chk("R5 hash enable", v, 32'(e));
                chk("R6 hash irq", {31'd0, irq}, {31'd0, |(s & e)});
                chk("R7 hash done", {31'd0, done_sum}, {31'd0, |(s & e & 4)});
                chk("R8 hash err", {31'd0, err_sum}, {31'd0, |(s & e & 11)});
            end
        end
        bus_wr(A_HE, 32'h0);

        // DMA sweep: R2 R6 R7 R8
        for (int b = 0; b < 9; b++) begin
            for (int m = 0; m < 2; m++) begin
                for (int k = 0; k < 2; k++) begin
                    logic [8:0] sb, eb, live;
                    sb = 9'(1 << b) & D_VALID;
                    eb = (k == 0) ? 9'(1 << b) : 9'h1FF;
                    eb = eb & D_VALID;
                    live = (m == 1) ? (sb & eb) : 9'd0;
                    clear_all();
                    bus_wr(A_DE, 32'(eb));
                    bus_wr(A_DG, 32'(m));
                    pulse(4'd0, 9'(1 << b));
                    rd(A_DS, v); chk("R2 dma status", v, 32'(sb));
                    rd(A_DG, v); chk("R6 dma unmask readback", v, 32'(m));
                    chk("R6 dma irq", {31'd0, irq}, {31'd0, |live});
                    chk("R7 dma done", {31'd0, done_sum}, {31'd0, live[0]});
                    chk("R8 dma err", {31'd0, err_sum}, {31'd0, |(live & 9'h1FC)});
                end
            end
        end

        // R3 partial clear, zero write, full clear
        clear_all();
        pulse(4'hF, 9'h1FF);
        bus_wr(A_HS, 32'h0);
        rd(A_HS, v); chk("R3 zero write keeps", v, 32'hF);
        bus_wr(A_HS, 32'h5);
        rd(A_HS, v); chk("R3 partial clear", v, 32'hA);
        bus_wr(A_DS, 32'h00C);
        rd(A_DS, v); chk("R3 dma partial clear", v, 32'h1F1);
        bus_wr(A_DS, 32'hFFFF_FFFF);
        rd(A_DS, v); chk("R3 dma full clear", v, 32'h0);

        // R4 event coinciding with clear
        clear_all();
        pulse(4'h1, 9'h004);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = A_HS; reg_wdata = 32'h5; hash_evt = 4'h6;
        @(negedge clk);
        reg_wr = 1'b0; hash_evt = '0;
        rd(A_HS, v); chk("R4 event beats clear", v, 32'h6);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = A_DS; reg_wdata = 32'h004; dma_evt = 9'h004;
        @(negedge clk);
        reg_wr = 1'b0; dma_evt = '0;
        rd(A_DS, v); chk("R4 dma event beats clear", v, 32'h004);

        // R5 sticky with enable off, then enabled, then disabled
        clear_all();
        bus_wr(A_HE, 32'h0);
        pulse(4'h8, 9'd0);
        repeat (3) @(negedge clk);
        rd(A_HS, v); chk("R5 sticky status", v, 32'h8);
        chk("R5 no irq while disabled", {31'd0, irq}, 0);
        bus_wr(A_HE, 32'hFFFF_FFFF);
        rd(A_HE, v); chk("R5 enable masked", v, 32'hF);
        chk("R5 irq once enabled", {31'd0, irq}, 1);
        bus_wr(A_HE, 32'h0);
        chk("R5 zero enable silences", {31'd0, irq}, 0);

        // R9 unmapped address
        clear_all();
        bus_wr(A_HE, 32'h3);
        bus_wr(A_DE, 32'h5);
        bus_wr(A_DG, 32'h1);
        pulse(4'h3, 9'h005);
        bus_wr(12'h058, 32'hFFFF_FFFF);
        bus_wr(12'h050 ^ 12'h800, 32'hFFFF_FFFF);
        rd(A_HS, v); chk("R9 hash status kept", v, 32'h3);
        rd(A_HE, v); chk("R9 hash enable kept", v, 32'h3);
        rd(A_DS, v); chk("R9 dma status kept", v, 32'h005);
        rd(A_DE, v); chk("R9 dma enable kept", v, 32'h005);
        rd(A_DG, v); chk("R9 unmask kept", v, 32'h1);
        rd(12'h058, v); chk("R9 unmapped reads zero", v, 32'h0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule